// File: doc/BRIEF.md
# Relative Branch Decision Unit

This block takes one branch request at a time and produces two things: whether the branch is taken, and the program counter to continue from. It works in one of two modes. In condition mode, a 4-bit selector picks one of sixteen tests on the N, Z, V and C flags. These cover the unsigned comparisons, the signed comparisons, the single-flag tests, and the unconditional pair. In bit-test mode, it checks a memory byte against an 8-bit mask. The test asks whether every masked bit is clear, or whether every masked bit is set. When the branch is taken, the next address is the fall-through address plus the sign-extended 8-bit offset, wrapping at 16 bits. When it is not taken, the next address is the fall-through address unchanged. The flags are inputs only; this block never changes them.

Requests enter on a valid/ready handshake and results leave on another. A request is transferred on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. The parameter `REG_OUT` chooses between two variants. With `REG_OUT=1` there is a single output register. A result appears on the cycle after it is accepted, and it stays unchanged while the consumer stalls. New input is accepted whenever the register is empty or is being drained in the same cycle. With `REG_OUT=0` the block is a pure combinational path: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. Fetching the instruction and reading the tested byte from memory are the caller's job.

Top module: `branch_resolver`

## Requirements
- R1: In condition mode (`in_bit_mode`=0), `in_cond` values 0 through 15 select these tests in order: always, never, higher, lower-or-same, carry clear, carry set, not equal, equal, overflow clear, overflow set, plus, minus, greater-or-equal, less-than, greater-than, less-or-equal. The flags are `in_flags[3]`=N, `[2]`=Z, `[1]`=V, `[0]`=C.
- R2: Higher is taken exactly when (C or Z) is 0. Lower-or-same is taken exactly when (C or Z) is 1.
- R3: Greater-or-equal is taken when (N xor V) is 0 and less-than when it is 1. Greater-than is taken when Z or (N xor V) is 0 and less-or-equal when it is 1.
- R4: A taken branch gives `out_pc` = `in_next_addr` + sign-extended `in_offset`, modulo 2^16.
- R5: A branch that is not taken gives `out_pc` = `in_next_addr`.
- R6: In bit-test mode (`in_bit_mode`=1) with `in_bit_set`=0, the branch is taken when (`in_mem` AND `in_mask`) is 0. With `in_bit_set`=1, it is taken when (NOT `in_mem` AND `in_mask`) is 0. A zero mask therefore always branches.
- R7: In bit-test mode, `in_cond` and `in_flags` have no effect on `out_taken` or `out_pc`.
- R8: With `REG_OUT=1`, an accepted request shows its result with `out_valid`=1 in the following cycle. While `out_valid`=1 and `out_ready`=0, `out_taken` and `out_pc` hold their values.
- R9: With `REG_OUT=1`, `out_valid` is 0 after reset. `in_ready` is 1 whenever the output register is empty or `out_ready` is 1, and 0 otherwise.
- R10: With `REG_OUT=0`, `out_valid` equals `in_valid`, `in_ready` equals `out_ready`, and the result is valid in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_bit_mode | input | 1 | 1 selects bit test, 0 selects flag condition |
| in_cond | input | 4 | Condition selector |
| in_flags | input | 4 | N, Z, V, C (bits 3..0) |
| in_bit_set | input | 1 | Bit test: 1 = branch if masked bits all set, 0 = all clear |
| in_mem | input | 8 | Byte under test |
| in_mask | input | 8 | Bits to test |
| in_offset | input | 8 | Signed displacement |
| in_next_addr | input | 16 | Address following the offset byte |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_taken | output | 1 | Branch taken |
| out_pc | output | 16 | Next program counter |

## Verification
The assertions check a set of rules on every cycle. A not-taken result must equal the fall-through address. A taken result must sit at the offset target. The never and always codes must give fixed results. A set carry must suppress the higher test. A masked hit must block the bits-clear branch. A stalled output must hold still, and every accepted request must produce a valid result. Some behaviours only the bench scenarios can show. These are the full mapping of all sixteen selectors across all flag combinations, wrap-around at both ends of the address space, the bits-set test over many byte and mask pairs, the claim that condition inputs are ignored in bit-test mode, and the exact order of acceptance and release around a stall.

// File: rtl/brr_pkg.sv
package brr_pkg;
  typedef enum logic [3:0] {
    BR_ALWAYS = 4'h0, BR_NEVER = 4'h1, BR_HI = 4'h2, BR_LS = 4'h3,
    BR_CC     = 4'h4, BR_CS    = 4'h5, BR_NE = 4'h6, BR_EQ = 4'h7,
    BR_VC     = 4'h8, BR_VS    = 4'h9, BR_PL = 4'hA, BR_MI = 4'hB,
    BR_GE     = 4'hC, BR_LT    = 4'hD, BR_GT = 4'hE, BR_LE = 4'hF
  } br_cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } ccr_t;
endpackage

// File: rtl/brr_cond_eval.sv
module brr_cond_eval
  import brr_pkg::*;
(
  input  logic [3:0] cond,
  input  ccr_t       flags,
  output logic       taken
);
  // Even codes hold the base test; odd codes are its complement.
  logic base;
  logic sgn_lt;

  always_comb begin
    sgn_lt = flags.n ^ flags.v;
    unique case (cond[3:1])
      3'd0: base = 1'b1;
      3'd1: base = ~(flags.c | flags.z);
      3'd2: base = ~flags.c;
      3'd3: base = ~flags.z;
      3'd4: base = ~flags.v;
      3'd5: base = ~flags.n;
      3'd6: base = ~sgn_lt;
      default: base = ~(flags.z | sgn_lt);
    endcase
    taken = base ^ cond[0];
  end
endmodule

// File: rtl/brr_bit_test.sv
module brr_bit_test #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] mem,
  input  logic [DATA_W-1:0] mask,
  input  logic              want_set,
  output logic              hit
);
  logic [DATA_W-1:0] probe;
  logic [DATA_W-1:0] residue;

  always_comb begin
    probe   = want_set ? ~mem : mem;
    residue = probe & mask;
    hit     = ~|residue;
  end
endmodule

// File: rtl/brr_target.sv
module brr_target #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  disp,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - OFF_W;
  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
    target   = base_addr + disp_ext;
  end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFF_W   = 8,
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit_mode,
  input  logic [3:0]        in_cond,
  input  logic [3:0]        in_flags,
  input  logic              in_bit_set,
  input  logic [DATA_W-1:0] in_mem,
  input  logic [DATA_W-1:0] in_mask,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic [ADDR_W-1:0] in_next_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_pc
);
  ccr_t              flags_s;
  logic              cond_hit;
  logic              bit_hit;
  logic              res_taken;
  logic [ADDR_W-1:0] jump_addr;
  logic [ADDR_W-1:0] res_pc;

  assign flags_s = ccr_t'(in_flags);

  brr_cond_eval u_cond (
    .cond  (in_cond),
    .flags (flags_s),
    .taken (cond_hit)
  );

  brr_bit_test #(.DATA_W(DATA_W)) u_bits (
    .mem      (in_mem),
    .mask     (in_mask),
    .want_set (in_bit_set),
    .hit      (bit_hit)
  );

  brr_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .base_addr (in_next_addr),
    .disp      (in_offset),
    .target    (jump_addr)
  );

  always_comb begin
    res_taken = in_bit_mode ? bit_hit : cond_hit;
    res_pc    = res_taken ? jump_addr : in_next_addr;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic              vld_q;
      logic              tkn_q;
      logic [ADDR_W-1:0] pc_q;
      logic              accept;

      assign in_ready = ~vld_q | out_ready;
      assign accept   = in_valid & in_ready;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          tkn_q <= 1'b0;
          pc_q  <= '0;
        end else begin
          if (accept) begin
            vld_q <= 1'b1;
            tkn_q <= res_taken;
            pc_q  <= res_pc;
          end else if (out_ready) begin
            vld_q <= 1'b0;
          end
        end
      end

      assign out_valid = vld_q;
      assign out_taken = tkn_q;
      assign out_pc    = pc_q;

      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pc) && $stable(out_taken)));
      p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_taken = res_taken;
      assign out_pc    = res_pc;
    end
  endgenerate

  p_fallthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !res_taken) |-> (res_pc == in_next_addr));
  p_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && res_taken) |-> (res_pc == jump_addr));
  p_never_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_bit_mode && in_cond == BR_NEVER) |-> !res_taken);
  p_always_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_bit_mode && in_cond == BR_ALWAYS) |-> res_taken);
  p_hi_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_bit_mode && in_cond == BR_HI && in_flags[0]) |-> !res_taken);
  p_bitclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_bit_mode && !in_bit_set && ((in_mem & in_mask) != '0)) |-> !res_taken);
endmodule

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        in_valid, in_bit_mode, in_bit_set, out_ready;
  logic [3:0]  in_cond, in_flags;
  logic [7:0]  in_mem, in_mask, in_offset;
  logic [15:0] in_next_addr;
  logic        in_ready, out_valid, out_taken;
  logic [15:0] out_pc;
  logic        c_in_ready, c_out_valid, c_out_taken;
  logic [15:0] c_out_pc;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  branch_resolver #(.REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit_mode(in_bit_mode), .in_cond(in_cond), .in_flags(in_flags),
    .in_bit_set(in_bit_set), .in_mem(in_mem), .in_mask(in_mask),
    .in_offset(in_offset), .in_next_addr(in_next_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_taken(out_taken), .out_pc(out_pc));

  branch_resolver #(.REG_OUT(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_bit_mode(in_bit_mode), .in_cond(in_cond), .in_flags(in_flags),
    .in_bit_set(in_bit_set), .in_mem(in_mem), .in_mask(in_mask),
    .in_offset(in_offset), .in_next_addr(in_next_addr),
    .out_valid(c_out_valid), .out_ready(out_ready),
    .out_taken(c_out_taken), .out_pc(c_out_pc));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit model_cond(input logic [3:0] cd, input logic [3:0] f);
    logic n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (cd)
      4'h0: return 1'b1;
      4'h1: return 1'b0;
      4'h2: return (c | z) == 1'b0;
      4'h3: return (c | z) == 1'b1;
      4'h4: return c == 1'b0;
      4'h5: return c == 1'b1;
      4'h6: return z == 1'b0;
      4'h7: return z == 1'b1;
      4'h8: return v == 1'b0;
      4'h9: return v == 1'b1;
      4'hA: return n == 1'b0;
      4'hB: return n == 1'b1;
      4'hC: return (n ^ v) == 1'b0;
      4'hD: return (n ^ v) == 1'b1;
      4'hE: return (z | (n ^ v)) == 1'b0;
      default: return (z | (n ^ v)) == 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] model_pc(input bit tk, input logic [15:0] nx, input logic [7:0] off);
    int signed d;
    d = $signed(off);
    return tk ? 16'((int'(nx) + d + 65536) % 65536) : nx;
  endfunction

  // Called just after a falling edge with inputs already set.
  task automatic apply(input string req, input bit exp_tk, input logic [15:0] exp_pc, input bit reg_too);
    #1;
    check(c_out_valid == 1'b1, "R10", 32'(c_out_valid), 32'd1);
    check(c_out_taken == exp_tk, req, 32'(c_out_taken), 32'(exp_tk));
    check(c_out_pc == exp_pc, req, 32'(c_out_pc), 32'(exp_pc));
    if (reg_too) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R8", 32'(out_valid), 32'd1);
      check(out_taken == exp_tk, req, 32'(out_taken), 32'(exp_tk));
      check(out_pc == exp_pc, req, 32'(out_pc), 32'(exp_pc));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit tk;
    logic [15:0] pa, pb;
    in_valid = 0; in_bit_mode = 0; in_bit_set = 0; out_ready = 1;
    in_cond = 0; in_flags = 0; in_mem = 0; in_mask = 0; in_offset = 0; in_next_addr = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R9 reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 idle", 32'(out_valid), 32'd0);

    // R1 R2 R3 R5: every selector against every flag combination.
    in_valid = 1; in_next_addr = 16'h4000; in_offset = 8'h10;
    for (int cd = 0; cd < 16; cd++) begin
      for (int f = 0; f < 16; f++) begin
        in_cond = 4'(cd); in_flags = 4'(f);
        tk = model_cond(4'(cd), 4'(f));
        apply((cd >= 12) ? "R3" : (cd == 2 || cd == 3) ? "R2" : "R1",
              tk, model_pc(tk, 16'h4000, 8'h10), 1'b1);
      end
    end

    // R4: every offset, with wrap at the top and bottom of the space.
    in_cond = 4'h0; in_flags = 4'h0;
    for (int o = 0; o < 256; o++) begin
      in_offset = 8'(o);
      in_next_addr = 16'hFFC0;
      apply("R4 wrap high", 1'b1, model_pc(1'b1, 16'hFFC0, 8'(o)), 1'b1);
      in_next_addr = 16'h0030;
      apply("R4 wrap low", 1'b1, model_pc(1'b1, 16'h0030, 8'(o)), 1'b0);
    end
    // R5: not-taken ignores the offset.
    in_cond = 4'h1; in_offset = 8'h80; in_next_addr = 16'h1234;
    apply("R5", 1'b0, 16'h1234, 1'b1);

    // R6 R7: bit tests over all bytes and several masks, with the flag
    // condition driven to the opposite answer to show it is ignored.
    in_bit_mode = 1; in_next_addr = 16'h8000; in_offset = 8'hF0;
    for (int sel = 0; sel < 2; sel++) begin
      for (int mk = 0; mk < 6; mk++) begin
        logic [7:0] m;
        case (mk)
          0: m = 8'h00; 1: m = 8'h01; 2: m = 8'h80;
          3: m = 8'hFF; 4: m = 8'h5A; default: m = 8'h0F;
        endcase
        for (int b = 0; b < 256; b++) begin
          logic [7:0] bb;
          bb = 8'(b);
          in_bit_set = sel[0]; in_mask = m; in_mem = bb;
          tk = sel[0] ? ((~bb & m) == 8'h00) : ((bb & m) == 8'h00);
          in_cond = tk ? 4'h1 : 4'h0;
          in_flags = 4'(b);
          apply(sel[0] ? "R6 set" : "R6 clear", tk, model_pc(tk, 16'h8000, 8'hF0), 1'b0);
        end
      end
    end
    // R7: same bit test with every selector gives the same result.
    in_bit_set = 0; in_mask = 8'h03; in_mem = 8'h04;
    for (int cd = 0; cd < 16; cd++) begin
      in_cond = 4'(cd); in_flags = 4'(15 - cd);
      apply("R7", 1'b1, model_pc(1'b1, 16'h8000, 8'hF0), 1'b0);
    end
    @(negedge clk);

    // R8 R9: stall behaviour.
    in_bit_mode = 0; in_valid = 0; out_ready = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 drain", 32'(out_valid), 32'd0);
    out_ready = 0; in_valid = 1; in_cond = 4'h0; in_next_addr = 16'h2000; in_offset = 8'h04;
    pa = 16'h2004;
    #1 check(in_ready == 1'b1, "R9 empty", 32'(in_ready), 32'd1);
    check(c_in_ready == 1'b0, "R10 ready", 32'(c_in_ready), 32'd0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_pc == pa, "R8 first", 32'(out_pc), 32'(pa));
    check(in_ready == 1'b0, "R9 full", 32'(in_ready), 32'd0);
    in_cond = 4'h1; in_next_addr = 16'h3000; pb = 16'h3000;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b1 && out_pc == pa && out_taken == 1'b1, "R8 hold", 32'(out_pc), 32'(pa));
    out_ready = 1;
    #1 check(in_ready == 1'b1, "R9 drain-accept", 32'(in_ready), 32'd1);
    @(negedge clk);
    check(out_valid == 1'b1 && out_pc == pb && out_taken == 1'b0, "R8 second", 32'(out_pc), 32'(pb));
    in_valid = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9 empty again", 32'(out_valid), 32'd0);
    check(c_out_valid == 1'b0, "R10 valid", 32'(c_out_valid), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule